// File: doc/BRIEF.md
# Execute-Lock Region Filter

This block sits between two upstream bus ports and a flash array. It watches each address phase and blocks instruction fetches into one protected boot region once a lock bit has been set. Every transfer is decoded against the region bounds, and bit 0 of its protection field decides whether it is an instruction fetch or a data access. A locked fetch that lands in the region is not forwarded. It is accepted on the spot and answered with an error pulse in the same cycle. All other transfers pass through unchanged.

The lock is a single sticky bit with write-once behaviour. Writing 1 sets it. Any later write is dropped without an error. Only reset clears it. Each port is a valid/ready stream. A forwarded transfer takes its back-pressure straight from the downstream ready. A blocked transfer is consumed at once, whatever the downstream ready is. Upstream must hold its address and protection fields stable while valid is high and ready is low.

Top module: `xprot_filter`

## Requirements
- R1: After reset the lock output is 0, and instruction fetches into the region are forwarded normally.
- R2: Protection bit 0 gives the access kind: 0 means instruction fetch and 1 means data access.
- R3: While the lock is 1, a valid instruction fetch whose address hits the region raises that port's error in the same cycle. Its downstream valid stays low and its upstream ready is high.
- R4: The filter applies to both ports independently, and one port's traffic never changes the other port's outputs.
- R5: Data accesses into the region are forwarded whatever the lock state, and they never raise an error.
- R6: Fetches whose address lies outside the region are forwarded whatever the lock state.
- R7: A configuration write with data 1 sets the lock, and the new value is visible from the next clock edge.
- R8: A configuration write with data 0 while the lock is clear leaves the lock at 0.
- R9: Once set, the lock ignores every further write and stays 1 until reset, and reset clears it.
- R10: A forwarded transfer has downstream valid equal to upstream valid and upstream ready equal to downstream ready. Its address and protection fields are copied unchanged.
- R11: An address hits the region when it is at least the base and below base plus size. The base is inclusive and the end is exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Lock register write strobe |
| cfg_wr_data | input | 1 | Lock register write data |
| lock_o | output | 1 | Current lock value |
| up_valid | input | NPORTS | Upstream address-phase valid, one per port |
| up_ready | output | NPORTS | Upstream ready, one per port |
| up_addr | input | NPORTS*ADDR_W | Upstream addresses, port 0 in the low bits |
| up_prot | input | NPORTS*PROT_W | Upstream protection fields, bit 0 = access kind |
| dn_valid | output | NPORTS | Downstream valid, one per port |
| dn_ready | input | NPORTS | Downstream ready, one per port |
| dn_addr | output | NPORTS*ADDR_W | Forwarded addresses |
| dn_prot | output | NPORTS*PROT_W | Forwarded protection fields |
| err | output | NPORTS | Error response for a blocked transfer, one per port |

## Verification
An 8-bit address configuration is swept over every address, both access kinds and alternating downstream ready on both ports at once. The second port carries a scrambled address and the opposite access kind. The sweep runs with the lock clear, with the lock set, and after a write of 0 to a set lock. This separates the region test from the access-kind test, exposes off-by-one errors at both bounds, and shows any leak between ports. Lock writes of 0 and 1 in both lock states, followed by a reset, cover the write-once rule.

// File: rtl/xpf_pkg.sv
package xpf_pkg;

  // Access kind as carried in protection bit 0
  typedef enum logic {
    ACC_FETCH = 1'b0,
    ACC_DATA  = 1'b1
  } acc_kind_e;

  localparam int unsigned KIND_BIT = 0;

  function automatic acc_kind_e kind_of(input logic prot_bit);
    return prot_bit ? ACC_DATA : ACC_FETCH;
  endfunction

endpackage

// File: rtl/xpf_region_dec.sv
module xpf_region_dec #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] SIZE = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // Extended by one bit so that base+size cannot wrap
  localparam logic [ADDR_W:0] LO = {1'b0, BASE};
  localparam logic [ADDR_W:0] HI = {1'b0, BASE} + {1'b0, SIZE};

  logic [ADDR_W:0] a_ext;

  always_comb begin
    a_ext = {1'b0, addr};
    hit   = (a_ext >= LO) && (a_ext < HI);
  end
endmodule

// File: rtl/xpf_lock_reg.sv
module xpf_lock_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_data,
  output logic lock
);
  logic set_req;

  // Only a 1 can change the bit. Writes once set are absorbed without error.
  always_comb set_req = wr_en && wr_data && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock <= 1'b0;
    else if (set_req) lock <= 1'b1;
  end
endmodule

// File: rtl/xpf_port_gate.sv
module xpf_port_gate
  import xpf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PROT_W = 4,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] SIZE = '1
) (
  input  logic              lock,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [PROT_W-1:0] up_prot,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [PROT_W-1:0] dn_prot,
  output logic              err
);
  logic      in_region;
  acc_kind_e kind;
  logic      blocked;

  xpf_region_dec #(
    .ADDR_W(ADDR_W),
    .BASE  (BASE),
    .SIZE  (SIZE)
  ) u_dec (
    .addr(up_addr),
    .hit (in_region)
  );

  always_comb begin
    kind     = kind_of(up_prot[KIND_BIT]);
    blocked  = lock && in_region && (kind == ACC_FETCH);
    // A blocked phase is consumed here and never reaches the flash
    dn_valid = up_valid && !blocked;
    up_ready = blocked ? 1'b1 : dn_ready;
    err      = up_valid && blocked;
    dn_addr  = up_addr;
    dn_prot  = up_prot;
  end
endmodule

// File: rtl/xprot_filter.sv
module xprot_filter #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PROT_W = 4,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0040_0000,
  parameter logic [ADDR_W-1:0] REGION_SIZE = 32'h0001_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr_en,
  input  logic                     cfg_wr_data,
  output logic                     lock_o,
  input  logic [NPORTS-1:0]        up_valid,
  output logic [NPORTS-1:0]        up_ready,
  input  logic [NPORTS*ADDR_W-1:0] up_addr,
  input  logic [NPORTS*PROT_W-1:0] up_prot,
  output logic [NPORTS-1:0]        dn_valid,
  input  logic [NPORTS-1:0]        dn_ready,
  output logic [NPORTS*ADDR_W-1:0] dn_addr,
  output logic [NPORTS*PROT_W-1:0] dn_prot,
  output logic [NPORTS-1:0]        err
);
  logic lock_q;

  xpf_lock_reg u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .wr_data(cfg_wr_data),
    .lock   (lock_q)
  );

  always_comb lock_o = lock_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    xpf_port_gate #(
      .ADDR_W(ADDR_W),
      .PROT_W(PROT_W),
      .BASE  (REGION_BASE),
      .SIZE  (REGION_SIZE)
    ) u_gate (
      .lock    (lock_q),
      .up_valid(up_valid[p]),
      .up_ready(up_ready[p]),
      .up_addr (up_addr[p*ADDR_W +: ADDR_W]),
      .up_prot (up_prot[p*PROT_W +: PROT_W]),
      .dn_valid(dn_valid[p]),
      .dn_ready(dn_ready[p]),
      .dn_addr (dn_addr[p*ADDR_W +: ADDR_W]),
      .dn_prot (dn_prot[p*PROT_W +: PROT_W]),
      .err     (err[p])
    );
  end
endmodule

// File: rtl/xprot_filter_chk.sv
module xprot_filter_chk #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned PROT_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_wr_en,
  input logic                     cfg_wr_data,
  input logic                     lock_o,
  input logic [NPORTS-1:0]        up_valid,
  input logic [NPORTS-1:0]        up_ready,
  input logic [NPORTS*PROT_W-1:0] up_prot,
  input logic [NPORTS-1:0]        dn_valid,
  input logic [NPORTS-1:0]        err
);
  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_o) |-> lock_o);

  // R7
  lock_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(cfg_wr_en && cfg_wr_data));

  // R1
  err_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err) |-> lock_o);

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R3
    err_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err[p] |-> (!dn_valid[p] && up_ready[p] && up_valid[p]));

    // R5
    data_never_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid[p] && up_prot[p*PROT_W]) |-> !err[p]);

    // R10
    valid_conserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid[p] |-> (dn_valid[p] ^ err[p]));
  end
endmodule

bind xprot_filter xprot_filter_chk #(
  .NPORTS(NPORTS),
  .PROT_W(PROT_W)
) u_xprot_filter_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_wr_data(cfg_wr_data),
  .lock_o     (lock_o),
  .up_valid   (up_valid),
  .up_ready   (up_ready),
  .up_prot    (up_prot),
  .dn_valid   (dn_valid),
  .err        (err)
);

// File: tb/test_xprot_filter.sv
`timescale 1ns/1ps
module test_xprot_filter;
  localparam int NP = 2;
  localparam int AW = 8;
  localparam int PW = 4;
  localparam logic [AW-1:0] BASE = 8'h40;
  localparam logic [AW-1:0] SIZE = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic cfg_wr_data = 1'b0;
  logic lock_o;
  logic [NP-1:0] up_valid = '0;
  logic [NP-1:0] up_ready;
  logic [NP*AW-1:0] up_addr = '0;
  logic [NP*PW-1:0] up_prot = '0;
  logic [NP-1:0] dn_valid;
  logic [NP-1:0] dn_ready = '0;
  logic [NP*AW-1:0] dn_addr;
  logic [NP*PW-1:0] dn_prot;
  logic [NP-1:0] err;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  xprot_filter #(
    .NPORTS(NP), .ADDR_W(AW), .PROT_W(PW),
    .REGION_BASE(BASE), .REGION_SIZE(SIZE)
  ) i_xprot_filter (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .lock_o(lock_o), .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .up_prot(up_prot), .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
    .dn_prot(dn_prot), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_data = 1'b0;
    #1;
  endtask

  // Check one port against the arithmetic model.
  // R2 R11: fetch = prot bit0 0, hit = BASE <= a < BASE+SIZE
  task automatic check_port(input int p, input logic lk, input string tag);
    logic [AW-1:0] a;
    logic [PW-1:0] pr;
    logic v, rdy, hit, blk;
    int exp_vec, act_vec;
    a   = up_addr[p*AW +: AW];
    pr  = up_prot[p*PW +: PW];
    v   = up_valid[p];
    rdy = dn_ready[p];
    hit = (int'(a) >= int'(BASE)) && (int'(a) < int'(BASE) + int'(SIZE));
    blk = lk && hit && (pr[0] == 1'b0);
    exp_vec = {v && blk, v && !blk, blk ? 1'b1 : rdy, a, pr};
    act_vec = {err[p], dn_valid[p], up_ready[p], dn_addr[p*AW +: AW], dn_prot[p*PW +: PW]};
    chk(act_vec == exp_vec, tag, act_vec, exp_vec);
  endtask

  // Both ports are driven at once with different traffic (R4)
  task automatic sweep(input logic lk, input string tag);
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        up_valid = {1'b1, (a % 7) != 3};
        dn_ready = {a[1], a[0] ^ k[0]};
        up_addr  = {8'(a) ^ 8'h5A, 8'(a)};
        up_prot  = {4'(4'b1010 | ~k[0]), 4'(4'b0110 | k[0])};
        #1;
        check_port(0, lk, tag);
        check_port(1, lk, tag);
      end
    end
    @(negedge clk);
    up_valid = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset value
    chk(lock_o == 1'b0, "R1 reset lock", lock_o, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(lock_o == 1'b0, "R1 lock after reset release", lock_o, 0);

    // R1 R6 R10 open sweep: nothing blocked
    sweep(1'b0, "R10 open sweep");

    // R8 writing 0 to a clear lock
    cfg_write(1'b0);
    chk(lock_o == 1'b0, "R8 zero write on clear lock", lock_o, 0);

    // R7 set
    cfg_write(1'b1);
    chk(lock_o == 1'b1, "R7 lock set", lock_o, 1);

    // R3 R5 R6 R11 locked sweep
    sweep(1'b1, "R3 locked sweep");

    // R9 write 0 ignored, behaviour unchanged
    cfg_write(1'b0);
    chk(lock_o == 1'b1, "R9 zero write on set lock", lock_o, 1);
    cfg_write(1'b1);
    chk(lock_o == 1'b1, "R9 repeat set", lock_o, 1);
    sweep(1'b1, "R9 post-write sweep");

    // R9 reset clears
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(lock_o == 1'b0, "R9 reset clears lock", lock_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R3 boundary fetches after reset are forwarded again
    @(negedge clk);
    up_valid = 2'b11; dn_ready = 2'b11;
    up_addr = {BASE + SIZE - 8'd1, BASE};
    up_prot = '0;
    #1;
    check_port(0, 1'b0, "R1 base fetch after reset");
    check_port(1, 1'b0, "R1 top fetch after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule